// File: doc/BRIEF.md
# Serial Command Front End for a Quad 8-bit DAC

This block is the serial receive path of a four-channel 8-bit DAC controller. A host drives an active-low select, a serial clock and a data line. The block oversamples all three on a fast system clock and collects bits into a 12-bit shift register. The first bit received is the most significant, and the word carries two address bits, two control bits and eight data bits in that order. Each time the select rises, the current register contents go to a downstream command decoder as a 12-bit bus with a one-cycle valid pulse.

The last stage of the shift register leaves the block as a serial output, so several devices can share one chain. The output can move on the falling serial-clock edge (mode 0, the reset mode) or on the rising edge (mode 1). The decoder chooses the mode through a small write port. A newly chosen mode takes effect when the next transfer begins.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset, `cmd_valid_o` is low, `dout_o` is 0, and the output edge mode is mode 0.
- R2: `din_i` is captured only on rising `sclk_i` edges while `csn_i` is low. Each captured bit enters bit 0 of the register and older bits move toward bit 11, so after 12 bits the first bit received sits at `cmd_o[11]`. Serial clock edges while `csn_i` is high change nothing.
- R3: Each rising edge of `csn_i` produces exactly one single-cycle `cmd_valid_o` pulse, with `cmd_o` equal to the register contents. A short transfer still issues a command: the new bits fill the low end, and the remaining upper bits are the older register contents.
- R4: When more than 12 bits are clocked in, only the last 12 are kept. The earlier bits are shifted out and lost.
- R5: In mode 0, `dout_o` changes only on falling `sclk_i` edges. A bit appears there on the falling edge that follows its 13th rising edge, which is 12.5 clocks after it was captured.
- R6: In mode 1, `dout_o` changes only on rising `sclk_i` edges. A bit appears there on the 12th rising edge after the one that captured it.
- R7: A pulse on `phase_wr_i` records `phase_mode_i` (0 for falling edge, 1 for rising edge). The recorded mode is applied at the next falling edge of `csn_i`, so a write made during a transfer does not change that transfer. The mode changes at no other time.
- R8: `dout_o` always drives a level. It holds its value while `csn_i` is high and while `sclk_i` is idle.
- R9: Reset clears the shift register, so a 4-bit transfer straight after reset yields a command whose upper 8 bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low select, asynchronous |
| din_i | input | 1 | Serial data in |
| phase_wr_i | input | 1 | Output-edge mode write strobe from the decoder |
| phase_mode_i | input | 1 | Mode to record: 0 falling edge, 1 rising edge |
| dout_o | output | 1 | Chained serial data out |
| cmd_o | output | 12 | Command word captured at the select rise |
| cmd_valid_o | output | 1 | One-cycle strobe marking a new `cmd_o` |

## Verification
The hardest case to reach is a mode write that arrives while a transfer is under way. The old edge mode must keep running until the select drops again. The stimulus writes the mode in the middle of a word and then compares `dout_o` on every settled system clock against a bit history that tracks where the mode actually switches. Short words and 16-bit words are mixed into the same history, so the bits carried across from earlier transfers are checked too.

// File: rtl/qdac_serial_front.sv
module qdac_serial_front #(
  parameter int WORD_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              din_i,
  input  logic              phase_wr_i,
  input  logic              phase_mode_i,
  output logic              dout_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              cmd_valid_o
);

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, din_sy;
  logic                   sclk_q, cs_q;
  logic [WORD_W-1:0]      sr;
  logic                   spill;
  logic                   mode_req, mode_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      din_sy  <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], csn_i};
      din_sy  <= {din_sy[SYNC_STAGES-2:0], din_i};
      sclk_q  <= sclk_sy[SYNC_STAGES-1];
      cs_q    <= cs_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_s    = sclk_sy[SYNC_STAGES-1];
  wire cs_s      = cs_sy[SYNC_STAGES-1];
  wire din_s     = din_sy[SYNC_STAGES-1];
  wire sclk_rise = sclk_s & ~sclk_q;
  wire sclk_fall = ~sclk_s & sclk_q;
  wire cs_rise   = cs_s & ~cs_q;
  wire cs_fall   = ~cs_s & cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      spill  <= 1'b0;
      dout_o <= 1'b0;
    end else if (!cs_s) begin
      if (sclk_rise) begin
        sr    <= {sr[WORD_W-2:0], din_s};
        spill <= sr[WORD_W-1];
        if (mode_cur) dout_o <= sr[WORD_W-1];
      end else if (sclk_fall && !mode_cur) begin
        dout_o <= spill;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_req <= 1'b0;
      mode_cur <= 1'b0;
    end else begin
      if (phase_wr_i) mode_req <= phase_mode_i;
      if (cs_fall)    mode_cur <= mode_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= cs_rise;
      if (cs_rise) cmd_o <= sr;
    end
  end

  // R3
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_s) |=> (sr[0] == $past(din_s)));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(dout_o));

  // R7
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(mode_cur));

  // R5
  mode0_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cur && sclk_rise) |=> $stable(dout_o));

  // R6
  mode1_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur && sclk_fall) |=> $stable(dout_o));

endmodule

// File: tb/qdac_serial_front_tb.sv
module qdac_serial_front_tb;
  localparam int W    = 12;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, din = 1'b0;
  logic phase_wr = 1'b0, phase_mode = 1'b0;
  logic dout;
  logic [W-1:0] cmd;
  logic cmd_valid;

  qdac_serial_front u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .din_i(din),
    .phase_wr_i(phase_wr), .phase_mode_i(phase_mode),
    .dout_o(dout), .cmd_o(cmd), .cmd_valid_o(cmd_valid));

  always #2 clk = ~clk;

  int  nchk = 0, nfail = 0;
  int  quiet = 0;
  int  pulses = 0;
  logic [W-1:0] got_cmd = '0;
  bit  hist[$];
  bit  exp_dout = 1'b0;
  bit  mode_req_m = 1'b0, mode_cur_m = 1'b0;
  string tag = "R1";
  bit  done = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      quiet++;
      if (cmd_valid) begin pulses++; got_cmd = cmd; end
      if (quiet >= 5) check(tag, {31'd0, dout}, {31'd0, exp_dout});
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[W-1-i] = hist[i+1];
    return w;
  endfunction

  task automatic sbit(bit d);
    din = d; quiet = 0;
    tick(HALF);
    sclk = 1'b1; quiet = 0;
    if (!csn) begin
      hist.push_back(d); void'(hist.pop_front());
      if (mode_cur_m) exp_dout = hist[0];
    end
    tick(HALF);
    sclk = 1'b0; quiet = 0;
    if (!csn && !mode_cur_m) exp_dout = hist[0];
  endtask

  task automatic cs_low();
    csn = 1'b0; quiet = 0; mode_cur_m = mode_req_m;
    tick(HALF);
  endtask

  task automatic cs_high(string req);
    tick(HALF);
    csn = 1'b1; quiet = 0; pulses = 0;
    tick(10);
    check(req, pulses, 1);
    check(req, got_cmd, model_word());
  endtask

  task automatic send(logic [15:0] v, int n, string req);
    cs_low();
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    cs_high(req);
  endtask

  task automatic set_phase(bit m);
    phase_wr = 1'b1; phase_mode = m;
    tick(1);
    phase_wr = 1'b0; mode_req_m = m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 13; i++) hist.push_back(1'b0);
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1", {31'd0, cmd_valid}, 0);
    check("R1", {31'd0, dout}, 0);
    // R9 short transfer after reset: upper bits zero
    tag = "R9";
    send(16'hB, 4, "R9");
    check("R9", got_cmd, 12'h00B);
    // R2 full words, mode 0 output lag
    tag = "R5";
    send(16'hA5C, 12, "R2");
    check("R2", got_cmd, 12'hA5C);
    send(16'h3E1, 12, "R2");
    // R3 partial word keeps older bits on top
    tag = "R3";
    send(16'h6D, 7, "R3");
    // R4 overlong word
    tag = "R4";
    send(16'hF0C3, 16, "R4");
    check("R4", got_cmd, 12'h0C3);
    // R7 mode write mid-transfer does not affect current word
    tag = "R7";
    cs_low();
    for (int i = 11; i >= 6; i--) sbit(i[0]);
    set_phase(1'b1);
    for (int i = 5; i >= 0; i--) sbit(i[1]);
    cs_high("R7");
    // R6 mode 1 from the next transfer
    tag = "R6";
    send(16'h96A, 12, "R6");
    send(16'h5F0, 12, "R6");
    send(16'h2B, 8, "R6");
    // R8 serial clocks with select high: ignored, output held
    tag = "R8";
    pulses = 0;
    for (int i = 0; i < 5; i++) sbit(1'b1);
    tick(8);
    check("R8", {31'd0, dout}, {31'd0, exp_dout});
    check("R8", pulses, 0);
    send(16'h000, 12, "R2");
    check("R2", got_cmd, model_word());
    // back to mode 0
    set_phase(1'b0);
    tag = "R5";
    send(16'hC3F, 12, "R5");
    send(16'h718, 13, "R4");
    tick(10);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule